// File: doc/BRIEF.md
# Directory Coherence Controller

This block is the home-node directory for a small group of processors sharing one memory. It holds one record per memory block: a three-way state (Uncached, Shared, Modified) and a presence vector with one bit per processor. A processor that misses in its own cache sends a read miss or a write miss to this controller. The controller looks up the record and decides whether other caches must be probed. If they must, it sends invalidations or fetch requests. Only the processors flagged in the presence vector receive them, so nothing is broadcast.

When probes are out, the controller waits for one acknowledgement from each probed processor. For a fetch, that acknowledgement also carries the returned data. Once the last one arrives, the controller writes the new record and sends a grant to the requester. While it waits, it accepts no new request. State changes follow the usual three-state invalidation protocol. Routing, data storage and any snooping below the directory are left to other blocks.

Top module: `dir_coherence_ctrl`

## Requirements
- R1: After reset every record is Uncached with an empty presence vector, `req_ready_o` is high and `msg_valid_o` is low.
- R2: A read miss to an Uncached or Shared block produces, in the cycle after acceptance, a grant message (type 0) to the requester alone. The block becomes Shared with the requester's bit added. Destination bit i addresses processor i.
- R3: A write miss to a Shared block held by others sends an invalidate (type 1) in the cycle after acceptance. Its destination is exactly the recorded sharers minus the requester.
- R4: After a probe, the grant to the requester appears in the cycle after the last outstanding acknowledgement. Until then no grant is sent. After an invalidate round the block is Modified with only the requester marked.
- R5: A read miss to a block Modified by another processor sends a fetch (type 2) to that owner only. After its acknowledgement the block is Shared with owner and requester marked.
- R6: A write miss to a block Modified by another processor sends a fetch-and-invalidate (type 3) to the owner only. After its acknowledgement the block is Modified with only the requester marked.
- R7: A write miss to an Uncached block, or to a Shared block whose only sharer is the requester, is granted in the cycle after acceptance with no probe. The block becomes Modified, owned by the requester.
- R8: A read or write miss from the current owner of a Modified block is granted at once with no probe, and the record is left unchanged.
- R9: `req_ready_o` is low from the cycle a probe is issued until the cycle the matching grant appears, and no request is accepted in that window.
- R10: An acknowledgement from a processor with no probe outstanding, including one received while idle, is ignored: it produces no message, does not end a wait and leaves every record unchanged.
- R11: Every message carries the block index on `msg_addr_o`. The records of different blocks are independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Miss request present |
| req_ready_o | output | 1 | Controller can take a request this cycle |
| req_write_i | input | 1 | 1 = write miss, 0 = read miss |
| req_src_i | input | SRC_W | Requesting processor |
| req_addr_i | input | IDX_W | Block index |
| msg_valid_o | output | 1 | Message valid (one-cycle pulse) |
| msg_type_o | output | 2 | 0 grant, 1 invalidate, 2 fetch, 3 fetch-and-invalidate |
| msg_dest_o | output | N_PROC | Destination mask, bit i = processor i |
| msg_addr_o | output | IDX_W | Block the message refers to |
| ack_valid_i | input | 1 | Acknowledgement or data return present |
| ack_src_i | input | SRC_W | Processor sending the acknowledgement |

## Verification
Every message is registered. A request accepted on one clock edge shows its grant or probe after that edge. The bench drives on the falling edge and samples at the next falling edge, so each result is read half a period after the edge that produced it. An acknowledgement driven on a falling edge is taken on the following rising edge. The grant after the last acknowledgement is therefore checked at the next falling edge. Any acknowledgement that is not the last, and any that does not match an outstanding probe, must leave the message output quiet in that same slot. The expected messages and records come from a bench model of the three-state directory. That model is updated only after each transaction completes.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [1:0] {
    DS_UNC = 2'd0,
    DS_SHR = 2'd1,
    DS_MOD = 2'd2
  } dir_state_e;

  typedef enum logic [1:0] {
    MT_GRANT     = 2'd0,
    MT_INV       = 2'd1,
    MT_FETCH     = 2'd2,
    MT_FETCH_INV = 2'd3
  } msg_type_e;

  typedef enum logic {
    CT_IDLE = 1'b0,
    CT_WAIT = 1'b1
  } ctl_state_e;
endpackage

// File: rtl/dir_entry_store.sv
module dir_entry_store
  import dir_pkg::*;
#(
  parameter int N_PROC  = 4,
  parameter int N_ENTRY = 16,
  localparam int IDX_W  = $clog2(N_ENTRY)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output dir_state_e        rd_state_o,
  output logic [N_PROC-1:0] rd_mask_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  dir_state_e        wr_state_i,
  input  logic [N_PROC-1:0] wr_mask_i
);
  dir_state_e        st_q [N_ENTRY];
  logic [N_PROC-1:0] mk_q [N_ENTRY];

  for (genvar e = 0; e < N_ENTRY; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q[e] <= DS_UNC;
        mk_q[e] <= '0;
      end else if (wr_en_i && (wr_idx_i == IDX_W'(e))) begin
        st_q[e] <= wr_state_i;
        mk_q[e] <= wr_mask_i;
      end
    end
  end

  assign rd_state_o = st_q[rd_idx_i];
  assign rd_mask_o  = mk_q[rd_idx_i];
endmodule

// File: rtl/dir_policy.sv
module dir_policy
  import dir_pkg::*;
#(
  parameter int N_PROC = 4,
  localparam int SRC_W = $clog2(N_PROC)
) (
  input  dir_state_e        cur_state_i,
  input  logic [N_PROC-1:0] cur_mask_i,
  input  logic              req_write_i,
  input  logic [SRC_W-1:0]  req_src_i,
  output logic [N_PROC-1:0] need_mask_o,
  output msg_type_e         probe_type_o,
  output dir_state_e        nxt_state_o,
  output logic [N_PROC-1:0] nxt_mask_o
);
  logic [N_PROC-1:0] req_bit;
  logic              is_owner;

  assign req_bit  = {{(N_PROC-1){1'b0}}, 1'b1} << req_src_i;
  assign is_owner = (cur_mask_i == req_bit);

  always_comb begin
    need_mask_o  = '0;
    probe_type_o = MT_INV;
    nxt_state_o  = cur_state_i;
    nxt_mask_o   = cur_mask_i;
    if (!req_write_i) begin
      if (cur_state_i == DS_MOD) begin
        if (!is_owner) begin
          need_mask_o  = cur_mask_i;
          probe_type_o = MT_FETCH;
          nxt_state_o  = DS_SHR;
          nxt_mask_o   = cur_mask_i | req_bit;
        end
      end else begin
        nxt_state_o = DS_SHR;
        nxt_mask_o  = cur_mask_i | req_bit;
      end
    end else begin
      nxt_state_o = DS_MOD;
      nxt_mask_o  = req_bit;
      unique case (cur_state_i)
        DS_SHR: begin
          need_mask_o  = cur_mask_i & ~req_bit;
          probe_type_o = MT_INV;
        end
        DS_MOD: begin
          if (!is_owner) begin
            need_mask_o  = cur_mask_i;
            probe_type_o = MT_FETCH_INV;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dir_ack_tracker.sv
module dir_ack_tracker #(
  parameter int N_PROC = 4,
  localparam int SRC_W = $clog2(N_PROC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [N_PROC-1:0] load_mask_i,
  input  logic              ack_valid_i,
  input  logic [SRC_W-1:0]  ack_src_i,
  output logic [N_PROC-1:0] pend_o,
  output logic              last_o
);
  logic [N_PROC-1:0] pend_q, ack_bit, remain;
  logic              hit;

  assign ack_bit = {{(N_PROC-1){1'b0}}, 1'b1} << ack_src_i;
  assign hit     = ack_valid_i && |(pend_q & ack_bit);
  assign remain  = pend_q & ~ack_bit;
  assign last_o  = hit && (remain == '0);
  assign pend_o  = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= '0;
    else if (load_i) pend_q <= load_mask_i;
    else if (hit)    pend_q <= remain;
  end
endmodule

// File: rtl/dir_coherence_ctrl.sv
module dir_coherence_ctrl
  import dir_pkg::*;
#(
  parameter int N_PROC  = 4,
  parameter int N_ENTRY = 16,
  localparam int SRC_W  = $clog2(N_PROC),
  localparam int IDX_W  = $clog2(N_ENTRY)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [SRC_W-1:0]  req_src_i,
  input  logic [IDX_W-1:0]  req_addr_i,
  output logic              msg_valid_o,
  output logic [1:0]        msg_type_o,
  output logic [N_PROC-1:0] msg_dest_o,
  output logic [IDX_W-1:0]  msg_addr_o,
  input  logic              ack_valid_i,
  input  logic [SRC_W-1:0]  ack_src_i
);
  ctl_state_e        ctl_q;
  logic [IDX_W-1:0]  addr_q;
  logic [SRC_W-1:0]  src_q;
  dir_state_e        nst_q;
  logic [N_PROC-1:0] nmk_q;

  dir_state_e        cur_state, pol_state, wr_state;
  logic [N_PROC-1:0] cur_mask, pol_mask, need_mask, wr_mask, pend;
  msg_type_e         probe_type;
  logic              accept, no_probe, last, wr_en, done;
  logic [IDX_W-1:0]  wr_idx;

  assign req_ready_o = (ctl_q == CT_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign no_probe    = (need_mask == '0);
  assign done        = (ctl_q == CT_WAIT) && last;

  dir_entry_store #(.N_PROC(N_PROC), .N_ENTRY(N_ENTRY)) i_store (
    .clk_i, .rst_ni,
    .rd_idx_i   (req_addr_i),
    .rd_state_o (cur_state),
    .rd_mask_o  (cur_mask),
    .wr_en_i    (wr_en),
    .wr_idx_i   (wr_idx),
    .wr_state_i (wr_state),
    .wr_mask_i  (wr_mask)
  );

  dir_policy #(.N_PROC(N_PROC)) i_policy (
    .cur_state_i  (cur_state),
    .cur_mask_i   (cur_mask),
    .req_write_i  (req_write_i),
    .req_src_i    (req_src_i),
    .need_mask_o  (need_mask),
    .probe_type_o (probe_type),
    .nxt_state_o  (pol_state),
    .nxt_mask_o   (pol_mask)
  );

  dir_ack_tracker #(.N_PROC(N_PROC)) i_tracker (
    .clk_i, .rst_ni,
    .load_i      (accept && !no_probe),
    .load_mask_i (need_mask),
    .ack_valid_i (ack_valid_i),
    .ack_src_i   (ack_src_i),
    .pend_o      (pend),
    .last_o      (last)
  );

  // commit either immediately on accept or when the last ack lands
  assign wr_en    = (accept && no_probe) || done;
  assign wr_idx   = done ? addr_q : req_addr_i;
  assign wr_state = done ? nst_q  : pol_state;
  assign wr_mask  = done ? nmk_q  : pol_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q       <= CT_IDLE;
      addr_q      <= '0;
      src_q       <= '0;
      nst_q       <= DS_UNC;
      nmk_q       <= '0;
      msg_valid_o <= 1'b0;
      msg_type_o  <= '0;
      msg_dest_o  <= '0;
      msg_addr_o  <= '0;
    end else begin
      msg_valid_o <= 1'b0;
      if (accept) begin
        msg_valid_o <= 1'b1;
        msg_addr_o  <= req_addr_i;
        if (no_probe) begin
          msg_type_o <= MT_GRANT;
          msg_dest_o <= {{(N_PROC-1){1'b0}}, 1'b1} << req_src_i;
        end else begin
          msg_type_o <= probe_type;
          msg_dest_o <= need_mask;
          ctl_q      <= CT_WAIT;
          addr_q     <= req_addr_i;
          src_q      <= req_src_i;
          nst_q      <= pol_state;
          nmk_q      <= pol_mask;
        end
      end else if (done) begin
        msg_valid_o <= 1'b1;
        msg_type_o  <= MT_GRANT;
        msg_dest_o  <= {{(N_PROC-1){1'b0}}, 1'b1} << src_q;
        msg_addr_o  <= addr_q;
        ctl_q       <= CT_IDLE;
      end
    end
  end
endmodule

// File: rtl/dir_checker.sv
module dir_checker #(
  parameter int N_PROC  = 4,
  parameter int N_ENTRY = 16,
  localparam int SRC_W  = $clog2(N_PROC),
  localparam int IDX_W  = $clog2(N_ENTRY)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              msg_valid_o,
  input logic [1:0]        msg_type_o,
  input logic [N_PROC-1:0] msg_dest_o,
  input logic              ack_valid_i,
  input logic [SRC_W-1:0]  src_q
);
  a_r2_grant_single_dest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && msg_type_o == 2'd0) |-> $countones(msg_dest_o) == 1);

  a_r3_probe_skips_requester: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && msg_type_o != 2'd0) |-> !msg_dest_o[src_q]);

  a_r5_fetch_single_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && msg_type_o[1]) |-> $countones(msg_dest_o) == 1);

  a_r9_busy_during_probe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && msg_type_o != 2'd0) |-> !req_ready_o);

  a_r11_dest_nonempty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> msg_dest_o != '0);

  a_r10_msg_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> ($past(req_valid_i && req_ready_o) || $past(ack_valid_i)));
endmodule

bind dir_coherence_ctrl dir_checker #(.N_PROC(N_PROC), .N_ENTRY(N_ENTRY)) i_dir_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .msg_valid_o (msg_valid_o),
  .msg_type_o  (msg_type_o),
  .msg_dest_o  (msg_dest_o),
  .ack_valid_i (ack_valid_i),
  .src_q       (src_q)
);

// File: tb/test_dir_coherence_ctrl.sv
`timescale 1ns/1ps
module test_dir_coherence_ctrl;
  localparam int NP = 4;
  localparam int NE = 16;
  localparam int SW = $clog2(NP);
  localparam int IW = $clog2(NE);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [SW-1:0] req_src = '0;
  logic [IW-1:0] req_addr = '0;
  logic          req_ready, msg_valid;
  logic [1:0]    msg_type;
  logic [NP-1:0] msg_dest;
  logic [IW-1:0] msg_addr;
  logic          ack_valid = 1'b0;
  logic [SW-1:0] ack_src = '0;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  // model: 0 Uncached, 1 Shared, 2 Modified
  logic [1:0]    m_st [NE];
  logic [NP-1:0] m_mk [NE];

  always #4 clk = ~clk;

  dir_coherence_ctrl #(.N_PROC(NP), .N_ENTRY(NE)) i_dir_coherence_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_src_i(req_src), .req_addr_i(req_addr),
    .msg_valid_o(msg_valid), .msg_type_o(msg_type),
    .msg_dest_o(msg_dest), .msg_addr_o(msg_addr),
    .ack_valid_i(ack_valid), .ack_src_i(ack_src)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void predict(input bit wr, input int src, input int adr,
                                  output logic [1:0] typ, output logic [NP-1:0] dst,
                                  output logic [1:0] nst, output logic [NP-1:0] nmk,
                                  output string tag);
    logic [NP-1:0] rb = NP'(1) << src;
    logic [1:0] s = m_st[adr];
    logic [NP-1:0] k = m_mk[adr];
    typ = 2'd0; dst = rb; nst = s; nmk = k;
    if (s == 2'd2 && k == rb) begin
      tag = "R8";
    end else if (!wr) begin
      nst = 2'd1; nmk = k | rb;
      if (s == 2'd2) begin typ = 2'd2; dst = k; tag = "R5"; end
      else tag = "R2";
    end else begin
      nst = 2'd2; nmk = rb;
      if (s == 2'd2) begin typ = 2'd3; dst = k; tag = "R6"; end
      else if (s == 2'd1 && (k & ~rb) != '0) begin typ = 2'd1; dst = k & ~rb; tag = "R3"; end
      else tag = "R7";
    end
  endfunction

  task automatic run_op(input bit wr, input int src, input int adr, input bit spur);
    logic [1:0] typ, nst;
    logic [NP-1:0] dst, nmk, pend;
    string tag;
    int start;
    predict(wr, src, adr, typ, dst, nst, nmk, tag);
    @(negedge clk);
    chk(req_ready == 1'b1, "R9 ready before request", req_ready, 1);
    req_valid = 1'b1; req_write = wr; req_src = SW'(src); req_addr = IW'(adr);
    @(negedge clk);
    req_valid = 1'b0;
    chk(msg_valid && msg_type == typ && msg_dest == dst, tag,
        {msg_valid, msg_type, msg_dest}, {1'b1, typ, dst});
    chk(msg_addr == IW'(adr), "R11 address", msg_addr, adr);
    if (typ != 2'd0) begin
      chk(req_ready == 1'b0, "R9 busy while probing", req_ready, 0);
      pend = dst;
      if (spur && pend != {NP{1'b1}}) begin
        for (int p = 0; p < NP; p++) if (!pend[p]) begin ack_src = SW'(p); break; end
        ack_valid = 1'b1;
        @(negedge clk);
        ack_valid = 1'b0;
        chk(!msg_valid && !req_ready, "R10 stray ack ignored", {msg_valid, req_ready}, 0);
      end
      start = $urandom_range(NP - 1);
      for (int i = 0; i < NP; i++) begin
        int p = (start + i) % NP;
        if (pend[p]) begin
          pend[p] = 1'b0;
          ack_valid = 1'b1; ack_src = SW'(p);
          @(negedge clk);
          ack_valid = 1'b0;
          if (pend != '0)
            chk(!msg_valid && !req_ready, "R4 wait for all acks", {msg_valid, req_ready}, 0);
        end
      end
      chk(msg_valid && msg_type == 2'd0 && msg_dest == (NP'(1) << src) && msg_addr == IW'(adr),
          "R4 grant after last ack", {msg_valid, msg_type, msg_dest}, {1'b1, 2'd0, NP'(1) << src});
    end
    m_st[adr] = nst; m_mk[adr] = nmk;
  endtask

  initial begin
    void'($urandom(32'd451));
    for (int e = 0; e < NE; e++) begin m_st[e] = 2'd0; m_mk[e] = '0; end
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && msg_valid == 1'b0, "R1 reset outputs", {req_ready, msg_valid}, 2'b10);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && msg_valid == 1'b0, "R1 idle after reset", {req_ready, msg_valid}, 2'b10);
    // directed
    run_op(0, 0, 3, 0);   // R2 from Uncached
    run_op(0, 1, 3, 0);   // R2 add sharer
    run_op(1, 2, 3, 1);   // R3 invalidate 0,1, R4
    run_op(0, 0, 3, 0);   // R5 fetch from 2
    run_op(1, 1, 3, 0);   // R3 invalidate 0,2
    run_op(1, 0, 0, 0);   // R7 from Uncached
    run_op(1, 0, 0, 0);   // R8 owner write
    run_op(0, 0, 0, 0);   // R8 owner read
    run_op(1, 3, 0, 1);   // R6 fetch-invalidate owner 0
    run_op(0, 3, 5, 0);
    run_op(1, 3, 5, 0);   // R7 sole sharer
    // R10 ack while idle
    @(negedge clk);
    ack_valid = 1'b1; ack_src = SW'(1);
    @(negedge clk);
    ack_valid = 1'b0;
    chk(!msg_valid && req_ready, "R10 idle ack ignored", {msg_valid, req_ready}, 1);
    run_op(0, 1, 5, 0);   // R5, proves record 5 untouched
    // random
    for (int n = 0; n < 400; n++)
      run_op($urandom_range(1), $urandom_range(NP - 1), $urandom_range(5), $urandom_range(3) == 0);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule